// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a watchdog timer on a small 32-bit register bus with separate write and read strobes, a byte address and a data word. The bus clock drives a two-stage divider: an 8-bit prescaler first, then a power-of-two stage that can divide by 16, 32, 64 or 128. Each output pulse of the divider, called a tick, moves a 16-bit down-counter one step. Software sets a reload value and starts the timer. It then services the watchdog by writing the live count again before the count runs out.

On the tick after the counter reaches zero, the counter reloads from the reload register and signals an expiry. An expiry can set a level interrupt, start a system reset pulse of fixed length, or both. Each of these has its own enable bit. A write of any value to the acknowledge address drops the interrupt. A write to the control register restarts both divider stages, so the first tick after that write arrives at a known time.

Top module: `prescaled_wdog`

## Requirements
- R1: After reset the control register reads 0x0000_8018, which means prescale 0x80, divider select 3 and all enables 0. The reload register at offset 0x4 and the count register at offset 0x8 both read 0x0000_8000. The interrupt and reset outputs are low.
- R2: The control register is at offset 0x0. Bit 0 enables reset, bit 2 enables the interrupt, bit 5 runs the timer, bits [4:3] select the divider and bits [15:8] hold the prescale value P. The register reads back in the same layout, with the other bits at 0. While the timer runs, a tick occurs every (P+1)·(16·2^select) clock cycles.
- R3: On each tick the count drops by one. On a tick with the count at 0, the counter instead loads the reload value and signals an expiry. With count N loaded, the expiry therefore falls on tick N+1.
- R4: A write to offset 0x8 loads bits [15:0] into the counter at that same clock edge. This write takes priority over a tick in the same cycle.
- R5: While the run bit is 0, the count holds its value.
- R6: An expiry with the interrupt enabled sets the interrupt output. The output stays high until any write to offset 0xC clears it. If an expiry and a clear fall in the same cycle, the set wins.
- R7: An expiry with reset enabled drives the reset output high for exactly 128 clock cycles, starting at the expiry edge. With reset disabled, the output stays low.
- R8: A write to the control register restarts both divider stages from zero. The first tick then falls exactly one tick period after the edge of that write.
- R9: A read of offset 0xC returns 0, and a read changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; read data is valid in the same cycle |
| bus_addr | input | 4 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero when no read is in progress |
| irq_o | output | 1 | Expiry interrupt, held until acknowledged |
| sysrst_o | output | 1 | System reset pulse, active high |

## Verification
The assertions assume that the write and read strobes are never high in the same cycle. They also assume that a write strobe lasts exactly one clock and that the address is a defined value whenever a strobe is high. The bench drives every access through tasks that raise one strobe just after an edge and drop it after the next edge, so the stimulus always meets these rules. The 128-cycle pulse window is checked with a length counter in the checker rather than a long delay. In the reset test the reload value is chosen so that no second expiry falls inside the pulse.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  // Register byte offsets
  localparam int unsigned OFS_CTRL   = 'h0;
  localparam int unsigned OFS_RELOAD = 'h4;
  localparam int unsigned OFS_COUNT  = 'h8;
  localparam int unsigned OFS_ACK    = 'hC;

  // Control field positions
  localparam int unsigned BIT_RSTEN = 0;
  localparam int unsigned BIT_IRQEN = 2;
  localparam int unsigned SEL_LSB   = 3;
  localparam int unsigned BIT_RUN   = 5;
  localparam int unsigned PRE_LSB   = 8;

  // Length in prescaler ticks of the second divider stage
  function automatic int unsigned div_length(input int unsigned sel,
                                             input int unsigned base_log2);
    return 32'd1 << (base_log2 + sel);
  endfunction

  // Clock cycles between counter ticks
  function automatic int unsigned tick_period(input int unsigned pre,
                                              input int unsigned sel,
                                              input int unsigned base_log2);
    return (pre + 1) * div_length(sel, base_log2);
  endfunction

endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned PRE_W  = 8,
  parameter int unsigned SEL_W  = 2,
  parameter logic [CNT_W-1:0] CNT_RST = 'h8000,
  parameter logic [PRE_W-1:0] PRE_RST = 'h80,
  parameter logic [SEL_W-1:0] SEL_RST = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [CNT_W-1:0]  count_q,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              rst_en,
  output logic              irq_en,
  output logic              run,
  output logic [SEL_W-1:0]  sel,
  output logic [PRE_W-1:0]  pre,
  output logic [CNT_W-1:0]  reload,
  output logic              ctrl_wr,
  output logic              cnt_wr,
  output logic              ack_wr
);

  logic reload_wr;
  logic unused_wdata;

  assign ctrl_wr   = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
  assign reload_wr = bus_wr && (bus_addr == ADDR_W'(OFS_RELOAD));
  assign cnt_wr    = bus_wr && (bus_addr == ADDR_W'(OFS_COUNT));
  assign ack_wr    = bus_wr && (bus_addr == ADDR_W'(OFS_ACK));
  assign unused_wdata = ^bus_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_en <= 1'b0;
      irq_en <= 1'b0;
      run    <= 1'b0;
      sel    <= SEL_RST;
      pre    <= PRE_RST;
      reload <= CNT_RST;
    end else begin
      if (ctrl_wr) begin
        rst_en <= bus_wdata[BIT_RSTEN];
        irq_en <= bus_wdata[BIT_IRQEN];
        run    <= bus_wdata[BIT_RUN];
        sel    <= bus_wdata[SEL_LSB +: SEL_W];
        pre    <= bus_wdata[PRE_LSB +: PRE_W];
      end
      if (reload_wr) reload <= bus_wdata[CNT_W-1:0];
    end
  end

  function automatic logic [DATA_W-1:0] ctrl_image(
    input logic r, input logic i, input logic g,
    input logic [SEL_W-1:0] s, input logic [PRE_W-1:0] p);
    logic [DATA_W-1:0] v;
    v = '0;
    v[BIT_RSTEN] = r;
    v[BIT_IRQEN] = i;
    v[BIT_RUN]   = g;
    v[SEL_LSB +: SEL_W] = s;
    v[PRE_LSB +: PRE_W] = p;
    return v;
  endfunction

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        ADDR_W'(OFS_CTRL):   bus_rdata = ctrl_image(rst_en, irq_en, run, sel, pre);
        ADDR_W'(OFS_RELOAD): bus_rdata = DATA_W'(reload);
        ADDR_W'(OFS_COUNT):  bus_rdata = DATA_W'(count_q);
        default:             bus_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/wdt_prescale.sv
module wdt_prescale
  import wdt_pkg::*;
#(
  parameter int unsigned PRE_W     = 8,
  parameter int unsigned SEL_W     = 2,
  parameter int unsigned BASE_LOG2 = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [PRE_W-1:0] pre,
  input  logic [SEL_W-1:0] sel,
  output logic             pre_tick,
  output logic             cnt_tick
);

  localparam int unsigned NSEL  = 2 ** SEL_W;
  localparam int unsigned DIV_W = BASE_LOG2 + NSEL - 1;

  logic [PRE_W-1:0] pre_q;
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] last_tab [NSEL];

  for (genvar g = 0; g < NSEL; g++) begin : g_last
    localparam int unsigned LEN = div_length(g, BASE_LOG2);
    assign last_tab[g] = DIV_W'(LEN - 1);
  end

  assign pre_tick = run && !restart && (pre_q == pre);
  assign cnt_tick = pre_tick && (div_q == last_tab[sel]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      div_q <= '0;
    end else if (restart || !run) begin
      pre_q <= '0;
      div_q <= '0;
    end else if (pre_tick) begin
      pre_q <= '0;
      div_q <= cnt_tick ? '0 : div_q + 1'b1;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int unsigned CNT_W = 16,
  parameter logic [CNT_W-1:0] CNT_RST = 'h8000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_tick,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] count_q,
  output logic             expire
);

  assign expire = cnt_tick && !cnt_wr && (count_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count_q <= CNT_RST;
    else if (cnt_wr)   count_q <= cnt_wdata;
    else if (expire)   count_q <= reload;
    else if (cnt_tick) count_q <= count_q - 1'b1;
  end

endmodule

// File: rtl/wdt_events.sv
module wdt_events #(
  parameter int unsigned RST_CYCLES = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic irq_en,
  input  logic rst_en,
  input  logic ack_wr,
  output logic irq_o,
  output logic sysrst_o
);

  localparam int unsigned PW = $clog2(RST_CYCLES + 1);

  logic [PW-1:0] pulse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                irq_o <= 1'b0;
    else if (expire && irq_en) irq_o <= 1'b1;
    else if (ack_wr)           irq_o <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pulse_q <= '0;
    else if (expire && rst_en) pulse_q <= PW'(RST_CYCLES);
    else if (pulse_q != '0)    pulse_q <= pulse_q - 1'b1;
  end

  assign sysrst_o = (pulse_q != '0);

endmodule

// File: rtl/prescaled_wdog.sv
module prescaled_wdog #(
  parameter int unsigned DATA_W        = 32,
  parameter int unsigned ADDR_W        = 4,
  parameter int unsigned CNT_W         = 16,
  parameter int unsigned PRE_W         = 8,
  parameter int unsigned SEL_W         = 2,
  parameter int unsigned DIV_BASE_LOG2 = 4,
  parameter int unsigned RST_CYCLES    = 128,
  parameter logic [CNT_W-1:0] CNT_RST  = 'h8000,
  parameter logic [PRE_W-1:0] PRE_RST  = 'h80,
  parameter logic [SEL_W-1:0] SEL_RST  = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o,
  output logic              sysrst_o
);

  // Internal events, named for the checker
  logic             rst_en, irq_en, run;
  logic [SEL_W-1:0] sel;
  logic [PRE_W-1:0] pre;
  logic [CNT_W-1:0] reload;
  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] cnt_wdata;
  logic             ctrl_wr, cnt_wr, ack_wr;
  logic             pre_tick, cnt_tick, expire;

  assign cnt_wdata = bus_wdata[CNT_W-1:0];

  wdt_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .PRE_W(PRE_W),
    .SEL_W(SEL_W), .CNT_RST(CNT_RST), .PRE_RST(PRE_RST), .SEL_RST(SEL_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .count_q(count_q),
    .bus_rdata(bus_rdata), .rst_en(rst_en), .irq_en(irq_en), .run(run),
    .sel(sel), .pre(pre), .reload(reload), .ctrl_wr(ctrl_wr),
    .cnt_wr(cnt_wr), .ack_wr(ack_wr)
  );

  wdt_prescale #(
    .PRE_W(PRE_W), .SEL_W(SEL_W), .BASE_LOG2(DIV_BASE_LOG2)
  ) u_prescale (
    .clk(clk), .rst_n(rst_n), .run(run), .restart(ctrl_wr),
    .pre(pre), .sel(sel), .pre_tick(pre_tick), .cnt_tick(cnt_tick)
  );

  wdt_counter #(
    .CNT_W(CNT_W), .CNT_RST(CNT_RST)
  ) u_counter (
    .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .cnt_wr(cnt_wr),
    .cnt_wdata(cnt_wdata), .reload(reload), .count_q(count_q),
    .expire(expire)
  );

  wdt_events #(
    .RST_CYCLES(RST_CYCLES)
  ) u_events (
    .clk(clk), .rst_n(rst_n), .expire(expire), .irq_en(irq_en),
    .rst_en(rst_en), .ack_wr(ack_wr), .irq_o(irq_o), .sysrst_o(sysrst_o)
  );

endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned RST_CYCLES = 128
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             rst_en,
  input logic             irq_en,
  input logic             ctrl_wr,
  input logic             cnt_wr,
  input logic             ack_wr,
  input logic             cnt_tick,
  input logic             expire,
  input logic [CNT_W-1:0] cnt_wdata,
  input logic [CNT_W-1:0] reload,
  input logic [CNT_W-1:0] count_q,
  input logic             irq_o,
  input logic             sysrst_o
);

  localparam int unsigned LEN_W = $clog2(RST_CYCLES + 2);

  logic [LEN_W-1:0] hi_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                hi_len <= '0;
    else if (expire && rst_en) hi_len <= LEN_W'(1);
    else if (sysrst_o)         hi_len <= hi_len + 1'b1;
    else                       hi_len <= '0;
  end

  p_tick_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_tick && !cnt_wr && count_q != '0) |=> count_q == $past(count_q) - 1'b1);

  p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> count_q == $past(reload));

  p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> count_q == $past(cnt_wdata));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_wr) |=> $stable(count_q));

  p_irq_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && irq_en) |=> irq_o);

  p_irq_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !ack_wr) |=> irq_o);

  p_irq_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_wr && !expire) |=> !irq_o);

  p_rst_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && rst_en) |=> sysrst_o);

  p_rst_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sysrst_o |-> hi_len <= LEN_W'(RST_CYCLES));

  p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> !cnt_tick);

endmodule

bind prescaled_wdog wdt_checker #(
  .CNT_W(CNT_W), .RST_CYCLES(RST_CYCLES)
) u_wdt_checker (
  .clk(clk), .rst_n(rst_n), .run(run), .rst_en(rst_en), .irq_en(irq_en),
  .ctrl_wr(ctrl_wr), .cnt_wr(cnt_wr), .ack_wr(ack_wr), .cnt_tick(cnt_tick),
  .expire(expire), .cnt_wdata(cnt_wdata), .reload(reload),
  .count_q(count_q), .irq_o(irq_o), .sysrst_o(sysrst_o)
);

// File: tb/test_prescaled_wdog.sv
module test_prescaled_wdog;

  localparam logic [3:0] A_CTRL = 4'h0, A_DATA = 4'h4, A_CNT = 4'h8, A_ACK = 4'hC;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o, sysrst_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int e_last = 0;
  bit finished = 0;

  typedef struct {
    int          what;   // 0 read data, 1 interrupt, 2 reset pulse
    logic [31:0] exp;
    string       req;
  } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  prescaled_wdog i_prescaled_wdog (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .sysrst_o(sysrst_o)
  );

  // Monitor: compares expected items against the outputs mid-cycle
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      exp_t it;
      logic [31:0] act;
      it = sb.pop_front();
      act = (it.what == 0) ? bus_rdata :
            (it.what == 1) ? {31'b0, irq_o} : {31'b0, sysrst_o};
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: actual %h expected %h", it.req, act, it.exp);
      end
    end
  end

  task automatic push(input int what, input logic [31:0] exp, input string req);
    exp_t it;
    it.what = what; it.exp = exp; it.req = req;
    sb.push_back(it);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
    e_last = cyc;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string req);
    bus_rd = 1'b1; bus_addr = a;
    push(0, exp, req);
    @(negedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic at_edge(input int n);
    while (cyc < n) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    int e0, e1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // R1 reset state
    rd(A_CTRL, 32'h0000_8018, "R1 ctrl");
    rd(A_DATA, 32'h0000_8000, "R1 reload");
    rd(A_CNT,  32'h0000_8000, "R1 count");
    push(1, 0, "R1 irq");
    push(2, 0, "R1 sysrst");
    @(negedge clk); #1;

    // R3/R6: count 3, period 16, interrupt only
    wr(A_DATA, 3);
    wr(A_CNT, 3);
    wr(A_CTRL, 32'h24);
    e0 = e_last;
    rd(A_CTRL, 32'h24, "R2 ctrl readback");
    at_edge(e0 + 16);
    rd(A_CNT, 2, "R3 first tick");
    at_edge(e0 + 48);
    rd(A_CNT, 0, "R3 reaches zero");
    push(1, 0, "R3 no expiry at zero");
    at_edge(e0 + 63);
    push(1, 0, "R6 irq before expiry");
    at_edge(e0 + 64);
    push(1, 1, "R6 irq on expiry");
    push(2, 0, "R7 reset disabled");
    rd(A_CNT, 3, "R3 reload on expiry");

    // R5 stop holds count, R6 level held
    wr(A_CTRL, 32'h04);
    rd(A_CNT, 3, "R5 count at stop");
    at_edge(cyc + 40);
    rd(A_CNT, 3, "R5 count held");
    push(1, 1, "R6 irq level held");
    wr(A_ACK, 32'hDEAD);
    push(1, 0, "R6 cleared by ack");
    rd(A_ACK, 0, "R9 ack reads zero");
    rd(A_CNT, 3, "R9 read no side effect");

    // R4 immediate load
    wr(A_CNT, 32'hFFFF_1234);
    rd(A_CNT, 32'h1234, "R4 count load");

    // R8 control write restarts dividers
    wr(A_DATA, 9);
    wr(A_CNT, 5);
    wr(A_CTRL, 32'h20);
    e0 = e_last;
    at_edge(e0 + 10);
    wr(A_CTRL, 32'h20);
    e1 = e_last;
    at_edge(e1 + 15);
    rd(A_CNT, 5, "R8 no tick before period");
    at_edge(e1 + 16);
    rd(A_CNT, 4, "R8 tick one period after write");
    wr(A_CTRL, 0);

    // R7 reset pulse, prescale 1, select 1: period 64
    wr(A_DATA, 4);
    wr(A_CNT, 1);
    wr(A_CTRL, 32'h0129);
    e0 = e_last;
    rd(A_CTRL, 32'h0129, "R2 prescale/select readback");
    at_edge(e0 + 64);
    rd(A_CNT, 0, "R2 period 64");
    at_edge(e0 + 127);
    push(2, 0, "R7 before expiry");
    at_edge(e0 + 128);
    push(2, 1, "R7 pulse start");
    push(1, 0, "R6 irq disabled");
    rd(A_CNT, 4, "R3 reload value");
    at_edge(e0 + 255);
    push(2, 1, "R7 pulse last cycle");
    at_edge(e0 + 256);
    push(2, 0, "R7 pulse ended");
    wr(A_CTRL, 0);

    // R2 select 3, prescale 0: period 128, count 0 expires on first tick
    wr(A_CNT, 0);
    wr(A_CTRL, 32'h3C);
    e0 = e_last;
    at_edge(e0 + 127);
    push(1, 0, "R2 select 3 before tick");
    at_edge(e0 + 128);
    push(1, 1, "R2 select 3 expiry");
    wr(A_CTRL, 0);
    wr(A_ACK, 0);
    push(1, 0, "R6 final clear");

    @(negedge clk); #1;
    @(negedge clk); #1;
    finished = 1;
    summary();
  end

endmodule